// File: doc/BRIEF.md
# Frame-Difference Motion Localizer

The block finds moving objects in a small grayscale video stream. Each pixel is compared with the pixel at the same place in the frame before it. The absolute difference is compared with a threshold to give a one-bit motion map, which is kept on chip together with a copy of the frame. While a frame streams in, the block adds up motion bits per column. After the last pixel it scans that column profile for runs of busy columns. Each run becomes a horizontal zone. For each zone the block then adds up motion bits per row, counting only the columns inside the zone, and finds the vertical extent from the first busy run of rows. The result is a short list of rectangles, one for each moving object.

Pixels arrive on a valid/ready stream in raster order. A start-of-frame flag marks the first pixel and an end-of-line flag marks the last pixel of each line. A pixel is taken on any cycle where valid and ready are both high. While the block analyses a finished frame it holds ready low, and the source must keep its pixel and flags stable until ready returns. The motion threshold and the minimum profile level are plain register inputs. They must be held constant while a frame or its analysis is in progress. Results are read from plain output pins while `done` is high.

Top module: `mloc_top`

## Requirements
- R1: A pixel is accepted only on a cycle with `pix_valid` and `pix_ready` both high. `pix_ready` is high on reset and between frames. It is low from the cycle after the last pixel of a frame (one with a stored previous frame) is accepted until the analysis of that frame finishes.
- R2: An accepted pixel with `pix_sof`=1 is pixel (0,0) of a new frame. The pixels after it are placed left to right and top to bottom. A line ends at a pixel with `pix_eol`=1 or at column W-1. The frame ends with the last pixel of row H-1. An accepted pixel outside a frame, one without `pix_sof` arriving after reset or after a frame end, is discarded and changes no stored state.
- R3: A pixel is marked as moving when the absolute difference between it and the stored pixel at the same place is strictly greater than `thresh`. A difference equal to `thresh` is not motion.
- R4: A horizontal zone is a maximal run of consecutive columns whose count of moving pixels is at least `min_level`. Its first and last columns become `x0` and `x1`.
- R5: For each zone, the row profile counts moving pixels in each row, using only the zone's columns. The first maximal run of rows with a count of at least `min_level` gives `y0` and `y1`. Later runs in the same zone are ignored. A zone with no such row produces no object.
- R6: Objects fill slots 0, 1, ... in order of increasing `x0`. Slot i occupies bits [i*XW +: XW] of `obj_x0` and `obj_x1` (XW = clog2(W)) and bits [i*YW +: YW] of `obj_y0` and `obj_y1` (YW = clog2(H)). In each slot, x0 <= x1 and y0 <= y1.
- R7: Only the leftmost MAXO (default 4) zones of a frame are considered; further zones are dropped. At most MAXO objects are reported, and `obj_count` gives the number of objects reported.
- R8: The first complete frame after reset has no previous frame. It produces `done`=1 with `obj_count`=0.
- R9: `done` rises when a frame's analysis ends and stays high until the last pixel of the next frame is accepted. While `done` is high, `obj_count` and the slots are valid, and every slot at or above `obj_count` reads zero.
- R10: After reset, `pix_ready`=1, `done`=0 and `obj_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thresh | input | PW | Motion threshold on the absolute pixel difference |
| min_level | input | SW | Minimum profile count for a column or row to count as busy |
| pix_valid | input | 1 | Pixel present on the stream |
| pix_ready | output | 1 | Block can take a pixel |
| pix_data | input | PW | Grayscale pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| done | output | 1 | Results of the last frame are valid |
| obj_count | output | CW | Number of objects reported |
| obj_x0 | output | MAXO*XW | Left column per slot |
| obj_x1 | output | MAXO*XW | Right column per slot |
| obj_y0 | output | MAXO*YW | Top row per slot |
| obj_y1 | output | MAXO*YW | Bottom row per slot |

## Verification
Flat frames with no change check the empty result and the first-frame rule. Frames with separated bright rectangles check that zones are found, sorted and bounded correctly. A step exactly at the threshold next to a step one level above it checks the strict comparison. A row of six narrow blocks checks that only four zones are kept. A one-pixel vertical line sharing no columns with the other objects checks that a zone whose row counts stay below the minimum is dropped. Two rectangles stacked in one zone check that only the first row run is used. A burst of bright pixels sent without a frame start, followed by a flat frame, would show up as false motion if the stray pixels had been stored. Random scenes with random threshold and minimum level are then compared against a software model of the same rules.

// File: rtl/mloc_pkg.sv
package mloc_pkg;
  typedef enum logic [2:0] {
    ST_CAP,   // streaming pixels in
    ST_COL,   // scanning column profile
    ST_COLW,  // drain last column run
    ST_ROW,   // scanning motion map for one zone
    ST_ROWW   // drain last row run, emit object
  } mloc_state_e;
endpackage

// File: rtl/mloc_run_det.sv
module mloc_run_det #(
  parameter int IW = 5,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          last,
  input  logic [IW-1:0] idx,
  input  logic [SW-1:0] sum,
  input  logic [SW-1:0] level,
  output logic          found,
  output logic [IW-1:0] f_start,
  output logic [IW-1:0] f_end
);
  logic          in_run;
  logic [IW-1:0] run_st;
  logic          busy;

  assign busy = sum >= level;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_run  <= 1'b0;
      run_st  <= '0;
      found   <= 1'b0;
      f_start <= '0;
      f_end   <= '0;
    end else begin
      found <= 1'b0;
      if (step) begin
        if (busy) begin
          if (!in_run) run_st <= idx;
          if (last) begin
            found   <= 1'b1;
            f_start <= in_run ? run_st : idx;
            f_end   <= idx;
            in_run  <= 1'b0;
          end else begin
            in_run <= 1'b1;
          end
        end else if (in_run) begin
          found   <= 1'b1;
          f_start <= run_st;
          f_end   <= idx - 1'b1;
          in_run  <= 1'b0;
        end
      end
    end
  end

  // a reported run never runs backwards
  assert_run_order_R4: assert property (@(posedge clk) disable iff (rst)
    found |-> (f_start <= f_end));
  // a run is only reported after a step
  assert_found_after_step_R5: assert property (@(posedge clk) disable iff (rst)
    found |-> $past(step));
endmodule

// File: rtl/mloc_store.sv
module mloc_store #(
  parameter int W  = 32,
  parameter int H  = 24,
  parameter int PW = 8,
  parameter int SW = 6,
  localparam int XW = $clog2(W),
  localparam int YW = $clog2(H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_x,
  input  logic [YW-1:0] wr_y,
  input  logic [PW-1:0] wr_pix,
  input  logic [PW-1:0] thresh,
  input  logic          use_prev,
  input  logic          col_clr,
  input  logic [XW-1:0] col_idx,
  output logic [SW-1:0] col_sum,
  input  logic [XW-1:0] rd_x,
  input  logic [YW-1:0] rd_y,
  output logic          map_bit
);
  localparam int N  = W * H;
  localparam int AW = $clog2(N);
  localparam int HS = $clog2(H + 1);

  logic [PW-1:0] prev_mem [N];
  logic          map_mem  [N];
  logic [HS-1:0] colsum   [W];

  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] old_pix, absd;
  logic          moving;

  assign wr_addr = AW'(wr_y) * AW'(W) + AW'(wr_x);
  assign rd_addr = AW'(rd_y) * AW'(W) + AW'(rd_x);
  assign old_pix = prev_mem[wr_addr];
  assign absd    = (wr_pix >= old_pix) ? (wr_pix - old_pix) : (old_pix - wr_pix);
  assign moving  = use_prev && (absd > thresh);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      prev_mem[wr_addr] <= wr_pix;
      map_mem[wr_addr]  <= moving;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < W; i++) colsum[i] <= '0;
    end else begin
      if (wr_en && moving) colsum[wr_x] <= colsum[wr_x] + 1'b1;
      if (col_clr) colsum[col_idx] <= '0;
    end
  end

  assign col_sum = SW'(colsum[col_idx]);
  assign map_bit = map_mem[rd_addr];

  // capture and column scan never overlap
  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (rst)
    col_clr |-> !wr_en);
endmodule

// File: rtl/mloc_top.sv
module mloc_top #(
  parameter int W    = 32,
  parameter int H    = 24,
  parameter int PW   = 8,
  parameter int MAXO = 4,
  localparam int XW  = $clog2(W),
  localparam int YW  = $clog2(H),
  localparam int CW  = $clog2(MAXO + 1),
  localparam int SW  = $clog2(((W > H) ? W : H) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     thresh,
  input  logic [SW-1:0]     min_level,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PW-1:0]     pix_data,
  input  logic              pix_sof,
  input  logic              pix_eol,
  output logic              done,
  output logic [CW-1:0]     obj_count,
  output logic [MAXO*XW-1:0] obj_x0,
  output logic [MAXO*XW-1:0] obj_x1,
  output logic [MAXO*YW-1:0] obj_y0,
  output logic [MAXO*YW-1:0] obj_y1
);
  import mloc_pkg::*;
  localparam int ZW = (MAXO > 1) ? $clog2(MAXO) : 1;

  mloc_state_e   state;
  logic [XW-1:0] x, sc, sx, cx;
  logic [YW-1:0] y, sy, cy;
  logic          in_frame, have_prev, got;
  logic [CW-1:0] zcount, zi;
  logic [XW-1:0] zx0 [MAXO];
  logic [XW-1:0] zx1 [MAXO];
  logic [SW-1:0] racc;
  logic [YW-1:0] ry0, ry1, oy0, oy1;

  logic fire, accept, line_end, frame_end;
  logic [SW-1:0] col_sum;
  logic map_bit, in_zone, rbit;
  logic c_found, r_found, zstore, rstore, got_n;
  logic [XW-1:0] c_st, c_en;
  logic [YW-1:0] r_st, r_en;
  logic [ZW-1:0] zsel, osel;
  logic [CW-1:0] zc_n;

  assign pix_ready = (state == ST_CAP);
  assign fire      = pix_valid && pix_ready;
  assign accept    = fire && (pix_sof || in_frame);
  assign cx        = pix_sof ? '0 : x;
  assign cy        = pix_sof ? '0 : y;
  assign line_end  = pix_eol || (cx == XW'(W - 1));
  assign frame_end = line_end && (cy == YW'(H - 1));

  assign zsel    = zi[ZW-1:0];
  assign osel    = obj_count[ZW-1:0];
  assign in_zone = (sx >= zx0[zsel]) && (sx <= zx1[zsel]);
  assign rbit    = map_bit && in_zone;
  assign zstore  = (state == ST_COL || state == ST_COLW) && c_found && (zcount < CW'(MAXO));
  assign rstore  = (state == ST_ROW || state == ST_ROWW) && r_found && !got;
  assign zc_n    = zcount + CW'(zstore);
  assign got_n   = got || rstore;
  assign oy0     = got ? ry0 : r_st;
  assign oy1     = got ? ry1 : r_en;

  mloc_store #(.W(W), .H(H), .PW(PW), .SW(SW)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(accept), .wr_x(cx), .wr_y(cy), .wr_pix(pix_data),
    .thresh(thresh), .use_prev(have_prev),
    .col_clr(state == ST_COL), .col_idx(sc), .col_sum(col_sum),
    .rd_x(sx), .rd_y(sy), .map_bit(map_bit)
  );

  mloc_run_det #(.IW(XW), .SW(SW)) u_col_det (
    .clk(clk), .rst(rst),
    .step(state == ST_COL), .last(sc == XW'(W - 1)),
    .idx(sc), .sum(col_sum), .level(min_level),
    .found(c_found), .f_start(c_st), .f_end(c_en)
  );

  mloc_run_det #(.IW(YW), .SW(SW)) u_row_det (
    .clk(clk), .rst(rst),
    .step(state == ST_ROW && sx == XW'(W - 1)), .last(sy == YW'(H - 1)),
    .idx(sy), .sum(racc + SW'(rbit)), .level(min_level),
    .found(r_found), .f_start(r_st), .f_end(r_en)
  );

  always_ff @(posedge clk) begin
    if (zstore) begin
      zx0[zcount[ZW-1:0]] <= c_st;
      zx1[zcount[ZW-1:0]] <= c_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CAP;
      x <= '0; y <= '0; sc <= '0; sx <= '0; sy <= '0;
      in_frame <= 1'b0; have_prev <= 1'b0; got <= 1'b0;
      zcount <= '0; zi <= '0; racc <= '0; ry0 <= '0; ry1 <= '0;
      done <= 1'b0; obj_count <= '0;
      obj_x0 <= '0; obj_x1 <= '0; obj_y0 <= '0; obj_y1 <= '0;
    end else begin
      if (zstore) zcount <= zc_n;
      if (rstore) begin
        got <= 1'b1; ry0 <= r_st; ry1 <= r_en;
      end
      case (state)
        ST_CAP: if (accept) begin
          x <= line_end ? '0 : cx + 1'b1;
          y <= line_end ? cy + 1'b1 : cy;
          in_frame <= !frame_end;
          if (frame_end) begin
            x <= '0; y <= '0;
            done <= 1'b0; obj_count <= '0;
            obj_x0 <= '0; obj_x1 <= '0; obj_y0 <= '0; obj_y1 <= '0;
            if (have_prev) begin
              state <= ST_COL; sc <= '0; zcount <= '0;
            end else begin
              have_prev <= 1'b1; done <= 1'b1;
            end
          end
        end
        ST_COL: begin
          sc <= sc + 1'b1;
          if (sc == XW'(W - 1)) state <= ST_COLW;
        end
        ST_COLW: begin
          if (zc_n == '0) begin
            done <= 1'b1; state <= ST_CAP;
          end else begin
            state <= ST_ROW; zi <= '0;
            sx <= '0; sy <= '0; racc <= '0; got <= 1'b0;
          end
        end
        ST_ROW: begin
          if (sx == XW'(W - 1)) begin
            sx <= '0; racc <= '0; sy <= sy + 1'b1;
            if (sy == YW'(H - 1)) state <= ST_ROWW;
          end else begin
            sx <= sx + 1'b1; racc <= racc + SW'(rbit);
          end
        end
        ST_ROWW: begin
          if (got_n) begin
            obj_x0[int'(osel)*XW +: XW] <= zx0[zsel];
            obj_x1[int'(osel)*XW +: XW] <= zx1[zsel];
            obj_y0[int'(osel)*YW +: YW] <= oy0;
            obj_y1[int'(osel)*YW +: YW] <= oy1;
            obj_count <= obj_count + 1'b1;
          end
          if (zi + 1'b1 == zcount) begin
            done <= 1'b1; state <= ST_CAP;
          end else begin
            zi <= zi + 1'b1; state <= ST_ROW;
            sx <= '0; sy <= '0; racc <= '0; got <= 1'b0;
          end
        end
        default: state <= ST_CAP;
      endcase
    end
  end

  // results are never shown while a frame is being analysed
  assert_no_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_ready |-> !done);
  assert_count_cap_R7: assert property (@(posedge clk) disable iff (rst)
    obj_count <= CW'(MAXO));
  // a stalled pixel is not consumed
  assert_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready && state == ST_ROWW && zi + 1'b1 == zcount) |=> pix_ready);

  for (genvar i = 0; i < MAXO; i++) begin : g_slot_chk
    assert_rect_shape_R6: assert property (@(posedge clk) disable iff (rst)
      (done && obj_count > CW'(i)) |->
        (obj_x0[i*XW +: XW] <= obj_x1[i*XW +: XW]) &&
        (obj_y0[i*YW +: YW] <= obj_y1[i*YW +: YW]));
    if (i + 1 < MAXO) begin : g_sort
      assert_rect_sorted_R6: assert property (@(posedge clk) disable iff (rst)
        (done && obj_count > CW'(i + 1)) |->
          (obj_x1[i*XW +: XW] < obj_x0[(i+1)*XW +: XW]));
    end
  end
endmodule

// File: tb/mloc_top_tb.sv
module mloc_top_tb;
  localparam int W = 32, H = 24, PW = 8, MAXO = 4;
  localparam int XW = $clog2(W), YW = $clog2(H), CW = $clog2(MAXO + 1);
  localparam int SW = $clog2(((W > H) ? W : H) + 1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1;
  logic [PW-1:0] thresh = 8'd10;
  logic [SW-1:0] min_level = 2;
  logic pix_valid = 0, pix_sof = 0, pix_eol = 0;
  logic [PW-1:0] pix_data = 0;
  logic pix_ready, done;
  logic [CW-1:0] obj_count;
  logic [MAXO*XW-1:0] obj_x0, obj_x1;
  logic [MAXO*YW-1:0] obj_y0, obj_y1;

  mloc_top #(.W(W), .H(H), .PW(PW), .MAXO(MAXO)) u_dut (
    .clk(clk), .rst(rst), .thresh(thresh), .min_level(min_level),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .done(done), .obj_count(obj_count),
    .obj_x0(obj_x0), .obj_x1(obj_x1), .obj_y0(obj_y0), .obj_y1(obj_y1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int cur [W*H];
  int prv [W*H];
  bit first = 1;
  int exp_cnt;
  int ex0 [MAXO], ex1 [MAXO], ey0 [MAXO], ey1 [MAXO];

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic fill(int b, int noise);
    for (int i = 0; i < W*H; i++)
      cur[i] = b + ((noise > 0) ? int'($urandom_range(0, noise)) : 0);
  endtask

  task automatic rect(int x0, int y0, int w, int h, int v);
    for (int yy = y0; yy < y0 + h && yy < H; yy++)
      for (int xx = x0; xx < x0 + w && xx < W; xx++)
        cur[yy*W + xx] = v;
  endtask

  // reference model of the requirements
  task automatic model();
    bit mp [W*H];
    int zs [MAXO], ze [MAXO];
    int nz, inrun, st, s, d, yf0, yf1, fnd;
    for (int i = 0; i < W*H; i++) begin
      d = cur[i] - prv[i];
      if (d < 0) d = -d;
      mp[i] = !first && (d > int'(thresh));
    end
    nz = 0; inrun = 0; st = 0;
    for (int c = 0; c < W; c++) begin
      s = 0;
      for (int r = 0; r < H; r++) s += mp[r*W + c];
      if (s >= int'(min_level)) begin
        if (!inrun) begin inrun = 1; st = c; end
      end else if (inrun) begin
        inrun = 0;
        if (nz < MAXO) begin zs[nz] = st; ze[nz] = c - 1; nz++; end
      end
    end
    if (inrun && nz < MAXO) begin zs[nz] = st; ze[nz] = W - 1; nz++; end
    exp_cnt = 0;
    for (int z = 0; z < nz; z++) begin
      inrun = 0; fnd = 0; yf0 = 0; yf1 = 0; st = 0;
      for (int r = 0; r < H; r++) begin
        s = 0;
        for (int c = zs[z]; c <= ze[z]; c++) s += mp[r*W + c];
        if (!fnd) begin
          if (s >= int'(min_level)) begin
            if (!inrun) begin inrun = 1; st = r; end
          end else if (inrun) begin
            inrun = 0; fnd = 1; yf0 = st; yf1 = r - 1;
          end
        end
      end
      if (!fnd && inrun) begin fnd = 1; yf0 = st; yf1 = H - 1; end
      if (fnd) begin
        ex0[exp_cnt] = zs[z]; ex1[exp_cnt] = ze[z];
        ey0[exp_cnt] = yf0; ey1[exp_cnt] = yf1; exp_cnt++;
      end
    end
  endtask

  task automatic send_pix(int p, bit sof, bit eol);
    @(negedge clk);
    pix_valid = 1; pix_data = PW'(p); pix_sof = sof; pix_eol = eol;
    while (!pix_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_eol = 0;
  endtask

  task automatic run_frame(string req);
    bit had_prev;
    had_prev = !first;
    model();
    for (int yy = 0; yy < H; yy++)
      for (int xx = 0; xx < W; xx++) begin
        if ($urandom_range(0, 5) == 0) idle();
        send_pix(cur[yy*W + xx], (xx == 0 && yy == 0), (xx == W - 1));
      end
    idle();
    if (had_prev) begin
      chk(pix_ready == 0, "R1", int'(pix_ready), 0);
      chk(done == 0, "R9", int'(done), 0);
    end
    while (!done) @(negedge clk);
    chk(done == 1, req, int'(done), 1);
    chk(int'(obj_count) == exp_cnt, req, int'(obj_count), exp_cnt);
    for (int i = 0; i < MAXO; i++) begin
      if (i < exp_cnt) begin
        chk(int'(obj_x0[i*XW +: XW]) == ex0[i], req, int'(obj_x0[i*XW +: XW]), ex0[i]);
        chk(int'(obj_x1[i*XW +: XW]) == ex1[i], req, int'(obj_x1[i*XW +: XW]), ex1[i]);
        chk(int'(obj_y0[i*YW +: YW]) == ey0[i], req, int'(obj_y0[i*YW +: YW]), ey0[i]);
        chk(int'(obj_y1[i*YW +: YW]) == ey1[i], req, int'(obj_y1[i*YW +: YW]), ey1[i]);
      end else begin
        chk(obj_x0[i*XW +: XW] == '0 && obj_y1[i*YW +: YW] == '0, "R9",
            int'(obj_x0[i*XW +: XW]), 0);
      end
    end
    for (int i = 0; i < W*H; i++) prv[i] = cur[i];
    first = 0;
  endtask

  initial begin
    int bg, nr;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk(pix_ready == 1, "R10", int'(pix_ready), 1);
    chk(done == 0, "R10", int'(done), 0);
    chk(obj_count == 0, "R10", int'(obj_count), 0);

    fill(40, 0); run_frame("R8");
    fill(40, 0); rect(3, 4, 5, 6, 120); rect(18, 10, 6, 5, 150); run_frame("R4");
    fill(40, 0); run_frame("R6");
    fill(40, 0); rect(2, 2, 3, 3, 50); rect(20, 5, 3, 3, 51); run_frame("R3");
    fill(40, 0); run_frame("R3");
    fill(40, 0);
    for (int k = 0; k < 6; k++) rect(1 + 5*k, 3, 3, 6, 100);
    run_frame("R7");
    fill(40, 0); run_frame("R7");
    fill(40, 0); rect(5, 2, 1, 11, 100); rect(12, 3, 4, 3, 100);
    rect(12, 15, 4, 4, 100); rect(25, 8, 3, 3, 100);
    run_frame("R5");
    // stray pixels without a frame start
    for (int k = 0; k < W + 5; k++) send_pix(255, 0, 0);
    idle();
    fill(40, 0); run_frame("R2");

    for (int f = 0; f < 8; f++) begin
      thresh = PW'($urandom_range(8, 20));
      min_level = SW'($urandom_range(1, 3));
      bg = $urandom_range(30, 60);
      fill(bg, 3);
      nr = $urandom_range(1, 5);
      for (int k = 0; k < nr; k++)
        rect($urandom_range(0, W - 1), $urandom_range(0, H - 1),
             $urandom_range(1, 8), $urandom_range(1, 8),
             bg + 30 + int'($urandom_range(0, 100)));
      run_frame("R4");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule